// File: doc/BRIEF.md
# Byte Lane Manipulation Unit

This execution unit performs byte- and word-granular operations on 64-bit data. Each operation takes a register operand `a_in`, a second operand `b_in` (a register value or a literal, already selected upstream) and a 4-bit operation code. The operations are:

- a lane-wise unsigned comparison
- lane clearing or lane keeping under an 8-bit lane mask
- logical shifts by a whole number of bytes, with low-part and high-part forms
- sign extension from a byte or from a halfword

All shift amounts are byte counts taken from `b_in[2:0]`. Lane masks come from `b_in[7:0]`.

The result is registered. A request presented with `valid_in` high produces its result and `valid_out` one clock later. When `valid_in` is low, the result register keeps its value. The high-part forms use a single shared byte shifter whose amount never reaches the full word width. When the byte offset is zero, these forms return zero.

Top module: `byte_manip_unit`

## Requirements
- R1: With op=4'h0, result bit i (i=0..7) is 1 exactly when byte i of A is greater than or equal to byte i of B, compared as unsigned 8-bit values; result bits 63:8 are zero.
- R2: With op=4'h1, result byte i is zero when B bit i is 1, and equals byte i of A otherwise.
- R3: With op=4'h2, result byte i equals byte i of A when B bit i is 1, and is zero otherwise.
- R4: With op=4'h3, the result is A shifted right logically by 8*B[2:0] bits.
- R5: With op=4'h4, the result is A shifted left by 8*B[2:0] bits; bits shifted past bit 63 are lost.
- R6: With op=4'h5, the result is B[7:0] with bit 7 copied into bits 63:8; A has no effect.
- R7: With op=4'h6, the result is B[15:0] with bit 15 copied into bits 63:16; A has no effect.
- R8: With op=4'h7 and k=B[2:0] nonzero, the result is A shifted left by 64-8k bits.
- R9: With op=4'h8 and k=B[2:0] nonzero, the result is A shifted right logically by 64-8k bits.
- R10: With op=4'h9 and k=B[2:0] nonzero, result bytes 0..k-1 are zero and bytes k..7 equal those of A.
- R11: With op=4'h7, 4'h8 or 4'h9 and B[2:0]=0, the result is zero.
- R12: B bits 63:8 have no effect on ops 4'h1, 4'h2; B bits 63:3 have no effect on ops 4'h3, 4'h4, 4'h7, 4'h8, 4'h9.
- R13: valid_out is high in the cycle after each cycle with valid_in high, and low otherwise; result holds its value across cycles with valid_in low.
- R14: Asserting rst_n low forces valid_out low at once, and valid_out stays low until a request is accepted after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| valid_in | input | 1 | Request strobe; also the result register enable |
| op_in | input | 4 | Operation code |
| a_in | input | 64 | Register operand A |
| b_in | input | 64 | Operand B (register or literal) |
| valid_out | output | 1 | Result valid, one cycle after valid_in |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its defaults: a 64-bit word and 8-bit lanes, which gives eight lanes and a 3-bit byte offset. With these values every offset from 0 to 7 can be reached, so the zero-offset path of the high-part forms and the largest seven-byte shift can both be driven directly. With only eight lanes, an all-ones or all-zeros lane mask and each single-lane compare can be set up by hand. Randomised requests for every code are then added, with upper B bits set, so that any dependence on bits the unit should ignore shows up at the result port.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [3:0] {
    OP_BYTE_GE     = 4'h0,
    OP_CLEAR_LANES = 4'h1,
    OP_KEEP_LANES  = 4'h2,
    OP_SHR_LO      = 4'h3,
    OP_SHL_LO      = 4'h4,
    OP_SEXT_LANE   = 4'h5,
    OP_SEXT_PAIR   = 4'h6,
    OP_SHL_HI      = 4'h7,
    OP_SHR_HI      = 4'h8,
    OP_MASK_HI     = 4'h9
  } bmu_op_e;

  localparam int unsigned OP_W = 4;

endpackage

// File: rtl/bmu_lane_cmp.sv
module bmu_lane_cmp #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NUM_LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0]    lhs,
  input  logic [DATA_W-1:0]    rhs,
  output logic [NUM_LANES-1:0] ge_flags
);

  // One unsigned comparator per lane.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign ge_flags[g] = (lhs[g*LANE_W +: LANE_W] >= rhs[g*LANE_W +: LANE_W]);
  end

endmodule

// File: rtl/bmu_lane_keep.sv
module bmu_lane_keep #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NUM_LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0]    data_in,
  input  logic [NUM_LANES-1:0] keep,
  output logic [DATA_W-1:0]    data_out
);

  // A lane passes when its keep bit is set; otherwise it is forced to zero.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign data_out[g*LANE_W +: LANE_W] = keep[g] ? data_in[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/bmu_byte_shift.sv
module bmu_byte_shift #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NUM_LANES = DATA_W / LANE_W,
  localparam int unsigned SHIFT_W   = $clog2(NUM_LANES)
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [SHIFT_W-1:0] lanes,
  input  logic               to_left,
  output logic [DATA_W-1:0]  data_out
);

  // Logarithmic barrel: stage s moves the word by 2**s lanes when lanes[s] is set.
  // The largest total move is NUM_LANES-1 lanes, so a full-word shift cannot occur.
  logic [DATA_W-1:0] stage [SHIFT_W+1];

  assign stage[0] = data_in;

  for (genvar s = 0; s < SHIFT_W; s++) begin : g_stage
    localparam int unsigned DIST = (1 << s) * LANE_W;
    logic [DATA_W-1:0] moved;
    assign moved        = to_left ? (stage[s] << DIST) : (stage[s] >> DIST);
    assign stage[s + 1] = lanes[s] ? moved : stage[s];
  end

  assign data_out = stage[SHIFT_W];

endmodule

// File: rtl/byte_manip_unit.sv
module byte_manip_unit
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              valid_out,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned NUM_LANES = DATA_W / LANE_W;
  localparam int unsigned SHIFT_W   = $clog2(NUM_LANES);
  localparam int unsigned PAIR_W    = 2 * LANE_W;

  bmu_op_e op;
  assign op = bmu_op_e'(op_in);

  // ---------------- operand decode ----------------
  logic [SHIFT_W-1:0]     offset;
  logic                   offset_zero;
  logic [SHIFT_W-1:0]     hi_lanes;
  logic                   is_hi_op;
  logic [2*NUM_LANES-1:0] hi_window;
  logic [NUM_LANES-1:0]   hi_clear;

  assign offset      = b_in[SHIFT_W-1:0];
  assign offset_zero = (offset == '0);
  // NUM_LANES - offset, taken modulo NUM_LANES: a two's complement negate.
  assign hi_lanes    = SHIFT_W'(~offset + 1'b1);
  assign is_hi_op    = (op == OP_SHL_HI) || (op == OP_SHR_HI) || (op == OP_MASK_HI);
  // All-ones lane mask moved up by the offset; its upper half marks the low lanes to clear.
  assign hi_window   = {{NUM_LANES{1'b0}}, {NUM_LANES{1'b1}}} << offset;
  assign hi_clear    = hi_window[2*NUM_LANES-1:NUM_LANES];

  // ---------------- lane compare ----------------
  logic [NUM_LANES-1:0] ge_flags;

  bmu_lane_cmp #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .lhs      (a_in),
    .rhs      (b_in),
    .ge_flags (ge_flags)
  );

  // ---------------- lane keep ----------------
  logic [NUM_LANES-1:0] keep_sel;
  logic [DATA_W-1:0]    kept;

  always_comb begin
    unique case (op)
      OP_CLEAR_LANES: keep_sel = ~b_in[NUM_LANES-1:0];
      OP_KEEP_LANES:  keep_sel = b_in[NUM_LANES-1:0];
      OP_MASK_HI:     keep_sel = ~hi_clear;
      default:        keep_sel = '1;
    endcase
  end

  bmu_lane_keep #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_keep (
    .data_in  (a_in),
    .keep     (keep_sel),
    .data_out (kept)
  );

  // ---------------- shared byte shifter ----------------
  logic               shift_left;
  logic [SHIFT_W-1:0] shift_lanes;
  logic [DATA_W-1:0]  shifted;

  assign shift_left  = (op == OP_SHL_LO) || (op == OP_SHL_HI);
  assign shift_lanes = is_hi_op ? hi_lanes : offset;

  bmu_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_shift (
    .data_in  (a_in),
    .lanes    (shift_lanes),
    .to_left  (shift_left),
    .data_out (shifted)
  );

  // ---------------- sign extension ----------------
  logic [DATA_W-1:0] sext_lane;
  logic [DATA_W-1:0] sext_pair;

  assign sext_lane = {{(DATA_W-LANE_W){b_in[LANE_W-1]}}, b_in[LANE_W-1:0]};
  assign sext_pair = {{(DATA_W-PAIR_W){b_in[PAIR_W-1]}}, b_in[PAIR_W-1:0]};

  // ---------------- result select (next state) ----------------
  logic [DATA_W-1:0] result_d;

  always_comb begin
    unique case (op)
      OP_BYTE_GE:     result_d = {{(DATA_W-NUM_LANES){1'b0}}, ge_flags};
      OP_CLEAR_LANES,
      OP_KEEP_LANES:  result_d = kept;
      OP_SHR_LO,
      OP_SHL_LO:      result_d = shifted;
      OP_SEXT_LANE:   result_d = sext_lane;
      OP_SEXT_PAIR:   result_d = sext_pair;
      OP_SHL_HI,
      OP_SHR_HI:      result_d = offset_zero ? '0 : shifted;
      OP_MASK_HI:     result_d = offset_zero ? '0 : kept;
      default:        result_d = '0;
    endcase
  end

  // ---------------- registers ----------------
  logic              valid_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_in;
    end
  end

  // Data path register: no reset, valid_in is its clock enable.
  always_ff @(posedge clk) begin
    if (valid_in) begin
      result_q <= result_d;
    end
  end

  assign valid_out = valid_q;
  assign result    = result_q;

endmodule

// File: rtl/byte_manip_unit_chk.sv
module byte_manip_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NUM_LANES = DATA_W / LANE_W,
  localparam int unsigned SHIFT_W   = $clog2(NUM_LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [3:0]        op_in,
  input logic [DATA_W-1:0] b_in,
  input logic              valid_out,
  input logic [DATA_W-1:0] result
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);  // R13

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);  // R13

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));  // R13

  AST_CMP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_in == 4'h0) |=> (result[DATA_W-1:NUM_LANES] == '0));  // R1

  AST_SEXT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_in == 4'h5) |=>
      (result == {{(DATA_W-LANE_W){$past(b_in[LANE_W-1])}}, $past(b_in[LANE_W-1:0])}));  // R6

  AST_SEXT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_in == 4'h6) |=>
      (result == {{(DATA_W-2*LANE_W){$past(b_in[2*LANE_W-1])}}, $past(b_in[2*LANE_W-1:0])}));  // R7

  AST_HI_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (op_in == 4'h7 || op_in == 4'h8 || op_in == 4'h9) &&
     b_in[SHIFT_W-1:0] == '0) |=> (result == '0));  // R11

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> !valid_out);  // R14

endmodule

bind byte_manip_unit byte_manip_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .op_in     (op_in),
  .b_in      (b_in),
  .valid_out (valid_out),
  .result    (result)
);

// File: tb/byte_manip_unit_tb.sv
module byte_manip_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [3:0]  op_in = '0;
  logic [63:0] a_in = '0;
  logic [63:0] b_in = '0;
  logic        valid_out;
  logic [63:0] result;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [63:0] value;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] last_exp = '0;

  always #2.5 clk = ~clk;

  byte_manip_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .op_in     (op_in),
    .a_in      (a_in),
    .b_in      (b_in),
    .valid_out (valid_out),
    .result    (result)
  );

  // Reference behaviour written from the requirements.
  function automatic logic [63:0] ref_model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    int k;
    k = int'(b[2:0]);
    r = '0;
    case (op)
      4'h0: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
      4'h1: for (int i = 0; i < 8; i++) r[8*i +: 8] = b[i] ? 8'h00 : a[8*i +: 8];
      4'h2: for (int i = 0; i < 8; i++) r[8*i +: 8] = b[i] ? a[8*i +: 8] : 8'h00;
      4'h3: r = a >> (8 * k);
      4'h4: r = a << (8 * k);
      4'h5: r = {{56{b[7]}}, b[7:0]};
      4'h6: r = {{48{b[15]}}, b[15:0]};
      4'h7: r = (k == 0) ? 64'h0 : (a << (64 - 8 * k));
      4'h8: r = (k == 0) ? 64'h0 : (a >> (64 - 8 * k));
      4'h9: if (k != 0) for (int i = 0; i < 8; i++) r[8*i +: 8] = (i < k) ? 8'h00 : a[8*i +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R4";
      4'h4: return "R5";
      4'h5: return "R6";
      4'h6: return "R7";
      4'h7: return "R8";
      4'h8: return "R9";
      4'h9: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one request per call, expected value pushed to the scoreboard.
  task automatic send(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                      input string tag);
    exp_t e;
    @(negedge clk);
    valid_in = 1'b1;
    op_in    = op;
    a_in     = a;
    b_in     = b;
    e.value  = ref_model(op, a, b);
    e.tag    = tag;
    last_exp = e.value;
    sb_q.push_back(e);
  endtask

  // Idle cycles with scrambled inputs: result must hold, valid_out must drop (R13).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R13 hold", result, last_exp);
        check("R13 valid low", {63'b0, valid_out}, 64'h0);
      end
      valid_in = 1'b0;
      op_in    = 4'($urandom);
      a_in     = {$urandom, $urandom};
      b_in     = {$urandom, $urandom};
    end
  endtask

  // Monitor: pops the scoreboard whenever a result is presented.
  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      if (sb_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R13 actual=unexpected valid_out expected=no result");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, result, e.value);
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [63:0] a_pat;
    a_pat = 64'h8877_6655_4433_2211;

    // R14: reset state
    repeat (3) @(negedge clk);
    check("R14 reset", {63'b0, valid_out}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 after release", {63'b0, valid_out}, 64'h0);

    // R1: lane compare
    send(4'h0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R1 all less");
    send(4'h0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R1 all equal");
    send(4'h0, 64'h80FF_007F_0102_FE01, 64'h7FFE_0180_0201_FF01, "R1 mixed unsigned");
    // R2 / R3: lane masks
    send(4'h1, a_pat, 64'h0000_0000_0000_00A5, "R2 clear");
    send(4'h1, a_pat, 64'h0000_0000_0000_00FF, "R2 clear all");
    send(4'h2, a_pat, 64'h0000_0000_0000_005A, "R3 keep");
    send(4'h2, a_pat, 64'h0000_0000_0000_0000, "R3 keep none");
    // R12: upper B bits ignored
    send(4'h1, a_pat, 64'hFFFF_FFFF_FFFF_FF00, "R12 clear upper B");
    send(4'h2, a_pat, 64'hABCD_0000_0000_0081, "R12 keep upper B");
    // R4 / R5: low shifts, including offset 0 and 7
    send(4'h3, a_pat, 64'h0000_0000_0000_0003, "R4 shr 3");
    send(4'h3, a_pat, 64'h0000_0000_0000_0007, "R4 shr 7");
    send(4'h3, a_pat, 64'hFFFF_FFFF_FFFF_FFF8, "R12 shr upper B");
    send(4'h4, a_pat, 64'h0000_0000_0000_0002, "R5 shl 2");
    send(4'h4, a_pat, 64'h0000_0000_0000_0007, "R5 shl 7");
    send(4'h4, a_pat, 64'h0000_0000_0000_0000, "R5 shl 0");
    // R6 / R7: sign extension, A random
    send(4'h5, {$urandom, $urandom}, 64'h0000_0000_0000_0080, "R6 neg");
    send(4'h5, {$urandom, $urandom}, 64'hFFFF_FFFF_FFFF_FF7F, "R6 pos");
    send(4'h6, {$urandom, $urandom}, 64'h0000_0000_0000_8001, "R7 neg");
    send(4'h6, {$urandom, $urandom}, 64'hFFFF_FFFF_FFFF_7FFF, "R7 pos");
    // R8 / R9 / R10: high forms
    send(4'h7, a_pat, 64'h0000_0000_0000_0001, "R8 off 1");
    send(4'h7, a_pat, 64'h0000_0000_0000_0007, "R8 off 7");
    send(4'h8, a_pat, 64'h0000_0000_0000_0001, "R9 off 1");
    send(4'h8, a_pat, 64'h0000_0000_0000_0005, "R9 off 5");
    send(4'h9, a_pat, 64'h0000_0000_0000_0003, "R10 off 3");
    send(4'h9, a_pat, 64'hFFFF_FFFF_FFFF_FFF7, "R10 off 7 upper B");
    // R11: zero offset on the high forms
    send(4'h7, a_pat, 64'hFFFF_FFFF_FFFF_FFF8, "R11 ext hi");
    send(4'h8, a_pat, 64'h0000_0000_0000_0010, "R11 ins hi");
    send(4'h9, a_pat, 64'h0000_0000_0000_0000, "R11 mask hi");
    idle(4);

    // Randomised requests for every code
    for (int n = 0; n < 300; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 9));
      send(op, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op));
      if ((n % 37) == 0) idle(3);
    end
    idle(3);

    // R14: asynchronous reset while a result is presented
    send(4'h3, a_pat, 64'h1, "R4 pre-reset");
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check("R14 async clear", {63'b0, valid_out}, 64'h0);
    sb_q.delete();
    @(negedge clk);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 stays low", {63'b0, valid_out}, 64'h0);
    send(4'h4, a_pat, 64'h1, "R5 post-reset");
    idle(3);

    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL R13 actual=%0d pending expected=0 pending", sb_q.size());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule